// File: doc/BRIEF.md
# Multi-Sector Erase Scheduler with Suspend

This block sits behind the command decoder of a flash array controller and turns a stream of decoded sector-erase requests into an ordered batch of per-sector erase operations. The first valid sector-erase request opens an acceptance window measured in microsecond ticks. Every further request inside the window adds its sector to a selection mask and starts the window again. A command that is not a sector-erase or a suspend cancels the whole batch. When the window runs out, the sectors that are selected and not protected are erased one after another, lowest index first. The erase of each sector is represented by a done handshake from the array model.

Suspend can be issued during the window or while a sector is being erased. It takes effect on the next clock edge, well within the allowed latency. A resume continues with the same sector. A batch in which every selected sector is protected reports busy for a fixed number of ticks and then returns to idle. A per-sector time limit flags a sector whose done handshake does not come in time and records the index of that sector. All windows and limits are tick counts set by parameters, so a simulation can use short ones.

Top module: `sector_erase_sched`

## Requirements
- R1: A sector-erase pulse whose index is valid opens the window, and `win_open` is high from the next cycle. Each further valid sector-erase pulse inside the window restarts the tick count. The erase starts on the WIN_TICKS-th `us_tick` after the last accepted request.
- R2: While the window is open, a `cmd_other` or `cmd_resume` pulse clears the batch and returns the block to idle, with all four status outputs low. Later ticks start no erase.
- R3: A sector-erase pulse with an index of NUM_SECT or more is ignored. In idle it opens no window.
- R4: Selected sectors are erased one at a time in ascending index order, and `cur_sect` holds the sector being erased. Sectors whose `prot_mask` bit is high when the window closes are skipped. Each `erase_done` pulse moves on to the next sector. After the last sector the block returns to idle.
- R5: If no selected sector is unprotected when the window closes, `all_prot` is high for exactly NOPROT_TICKS ticks, and the block then returns to idle.
- R6: A `cmd_suspend` pulse during erasing or during the window sets `suspended` on the next cycle and clears `erasing` and `win_open`.
- R7: While suspended, further suspend, sector-erase and other-command pulses and any number of ticks leave the block suspended.
- R8: A `cmd_resume` pulse while suspended restarts erasing of the same sector. A resume while erasing is ignored. Suspend may be issued again after a resume.
- R9: In idle, suspend, resume and other-command pulses have no effect.
- R10: If `erase_done` does not arrive within LIMIT_TICKS ticks of erasing one sector, with ticks during suspension not counted, `fail` goes high, `fail_sect` holds that sector, and the block returns to idle. The next accepted request clears `fail`.
- R11: After reset all status outputs and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_erase | input | 1 | Decoded sector-erase pulse |
| cmd_suspend | input | 1 | Decoded erase-suspend pulse |
| cmd_resume | input | 1 | Decoded erase-resume pulse |
| cmd_other | input | 1 | Any other decoded command |
| sect_idx | input | IDX_W | Sector index for cmd_erase |
| prot_mask | input | NUM_SECT | Per-sector protection, 1 = protected |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| erase_done | input | 1 | Current sector erase finished |
| cur_sect | output | IDX_W | Sector currently selected for erase |
| win_open | output | 1 | Acceptance window open |
| erasing | output | 1 | A sector is being erased |
| suspended | output | 1 | Erase suspended |
| all_prot | output | 1 | Every selected sector protected, busy period |
| fail | output | 1 | Sector time limit exceeded |
| fail_sect | output | IDX_W | Index of the failing sector |

## Verification
The bench builds the block with seven sectors and a three-bit index. It uses WIN_TICKS of 4, NOPROT_TICKS of 5 and LIMIT_TICKS of 12, so that the window restart, the all-protected busy period and the time-limit failure each finish within a few dozen ticks. The short limit makes it possible to check the cycle just before expiry and the cycle of expiry. Index 7 stays reachable as the single out-of-range value.

// File: rtl/ses_pkg.sv
package ses_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WIN,
      ST_ERASE,
      ST_SUSP,
      ST_NOPROT
   } ses_state_e;
endpackage

// File: rtl/ses_tick_timer.sv
// Counts enabled ticks up to a terminal count; clear has priority.
module ses_tick_timer #(
   parameter int TC = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic tick,
   output logic expired
);
   localparam int CW = (TC < 2) ? 1 : $clog2(TC);

   generate
      if (TC < 1) begin : g_bad_tc
         $error("ses_tick_timer: TC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          at_end;

   assign at_end  = (cnt_q == CW'(TC - 1));
   assign expired = run & tick & ~clr & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (run && tick) begin
         cnt_q <= at_end ? '0 : cnt_q + CW'(1);
      end
   end

   // R1: the count never passes the terminal value
   a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt_q) <= TC - 1));
endmodule

// File: rtl/ses_pick.sv
// Selects one pending sector; SCAN_UP picks the lowest index, else the highest.
module ses_pick #(
   parameter int N       = 7,
   parameter int IW      = 3,
   parameter bit SCAN_UP = 1'b1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   assign any = |req;

   generate
      if (SCAN_UP) begin : g_low_first
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) idx = IW'(i);
            end
         end
      end else begin : g_high_first
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) idx = IW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sector_erase_sched.sv
module sector_erase_sched
   import ses_pkg::*;
#(
   parameter int NUM_SECT     = 7,
   parameter int IDX_W        = 3,
   parameter int WIN_TICKS    = 80,
   parameter int NOPROT_TICKS = 100,
   parameter int LIMIT_TICKS  = 1000000,
   parameter bit SCAN_UP      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_erase,
   input  logic                cmd_suspend,
   input  logic                cmd_resume,
   input  logic                cmd_other,
   input  logic [IDX_W-1:0]    sect_idx,
   input  logic [NUM_SECT-1:0] prot_mask,
   input  logic                us_tick,
   input  logic                erase_done,
   output logic [IDX_W-1:0]    cur_sect,
   output logic                win_open,
   output logic                erasing,
   output logic                suspended,
   output logic                all_prot,
   output logic                fail,
   output logic [IDX_W-1:0]    fail_sect
);
   localparam logic [NUM_SECT-1:0] ONE = NUM_SECT'(1);

   generate
      if (NUM_SECT < 1 || NUM_SECT > (1 << IDX_W)) begin : g_bad_sect
         $error("sector_erase_sched: NUM_SECT does not fit IDX_W");
      end
   endgenerate

   ses_state_e          state_q, state_d;
   logic [NUM_SECT-1:0] sel_q, sel_d;
   logic                fail_q, fail_d;
   logic [IDX_W-1:0]    fsect_q, fsect_d;

   logic                idx_ok, accept;
   logic [NUM_SECT-1:0] add_bit, cur_bit, live;
   logic [IDX_W-1:0]    pick_idx;
   logic                pick_any;
   logic                win_exp, np_exp, lim_exp;

   assign idx_ok  = (int'(sect_idx) < NUM_SECT);
   assign add_bit = idx_ok ? (ONE << sect_idx) : '0;
   assign accept  = cmd_erase && idx_ok &&
                    (state_q == ST_IDLE || state_q == ST_WIN);
   assign cur_bit = ONE << pick_idx;
   assign live    = sel_q & ~prot_mask;

   ses_pick #(.N(NUM_SECT), .IW(IDX_W), .SCAN_UP(SCAN_UP)) u_pick (
      .req (sel_q),
      .idx (pick_idx),
      .any (pick_any)
   );

   ses_tick_timer #(.TC(WIN_TICKS)) u_win_tmr (
      .clk, .rst_n,
      .clr     (accept),
      .run     (state_q == ST_WIN),
      .tick    (us_tick),
      .expired (win_exp)
   );

   ses_tick_timer #(.TC(NOPROT_TICKS)) u_np_tmr (
      .clk, .rst_n,
      .clr     (state_q != ST_NOPROT),
      .run     (state_q == ST_NOPROT),
      .tick    (us_tick),
      .expired (np_exp)
   );

   ses_tick_timer #(.TC(LIMIT_TICKS)) u_lim_tmr (
      .clk, .rst_n,
      .clr     (erase_done || !(state_q == ST_ERASE || state_q == ST_SUSP)),
      .run     (state_q == ST_ERASE),
      .tick    (us_tick),
      .expired (lim_exp)
   );

   always_comb begin
      state_d = state_q;
      sel_d   = sel_q;
      fail_d  = fail_q;
      fsect_d = fsect_q;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               sel_d   = add_bit;
               fail_d  = 1'b0;
               state_d = ST_WIN;
            end
         end
         ST_WIN: begin
            if (cmd_erase) begin
               sel_d = sel_q | add_bit;
            end else if (cmd_suspend) begin
               sel_d   = live;
               state_d = ST_SUSP;
            end else if (cmd_resume || cmd_other) begin
               sel_d   = '0;
               state_d = ST_IDLE;
            end else if (win_exp) begin
               sel_d   = live;
               state_d = (|live) ? ST_ERASE : ST_NOPROT;
            end
         end
         ST_ERASE: begin
            if (erase_done) begin
               sel_d = sel_q & ~cur_bit;
               if ((sel_q & ~cur_bit) == '0) state_d = ST_IDLE;
               else if (cmd_suspend)         state_d = ST_SUSP;
            end else if (lim_exp) begin
               fail_d  = 1'b1;
               fsect_d = pick_idx;
               sel_d   = '0;
               state_d = ST_IDLE;
            end else if (cmd_suspend) begin
               state_d = ST_SUSP;
            end
         end
         ST_SUSP: begin
            if (cmd_resume) state_d = pick_any ? ST_ERASE : ST_NOPROT;
         end
         ST_NOPROT: begin
            if (np_exp) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= '0;
         fail_q  <= 1'b0;
         fsect_q <= '0;
      end else begin
         state_q <= state_d;
         sel_q   <= sel_d;
         fail_q  <= fail_d;
         fsect_q <= fsect_d;
      end
   end

   assign cur_sect  = pick_idx;
   assign win_open  = (state_q == ST_WIN);
   assign erasing   = (state_q == ST_ERASE);
   assign suspended = (state_q == ST_SUSP);
   assign all_prot  = (state_q == ST_NOPROT);
   assign fail      = fail_q;
   assign fail_sect = fsect_q;

   // R2: another command inside the window drops the batch
   a_r2_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && !cmd_erase && !cmd_suspend && (cmd_other || cmd_resume))
      |=> (!win_open && !erasing && !suspended && !all_prot));

   // R4: the sector under erase holds until its done handshake
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (erasing && !erase_done && !cmd_suspend && !lim_exp)
      |=> (erasing && $stable(cur_sect)));

   // R6: suspend during erase lands on the next cycle
   a_r6_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (erasing && cmd_suspend && !erase_done && !lim_exp) |=> suspended);

   // R7: only resume leaves the suspended state
   a_r7_stay: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended && !cmd_resume) |=> suspended);

   // R9: idle stays idle without a sector-erase request
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_open && !erasing && !suspended && !all_prot && !cmd_erase)
      |=> (!win_open && !erasing && !suspended && !all_prot));

   // R10: a time-limit failure ends the erase
   a_r10_fail_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> (!erasing && !win_open));
endmodule

// File: tb/sector_erase_sched_tb_top.sv
module sector_erase_sched_tb_top;
   localparam int CLK_P  = 10;
   localparam int NS     = 7;
   localparam int IW     = 3;
   localparam int WIN    = 4;
   localparam int NPROT  = 5;
   localparam int LIMIT  = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_erase = 1'b0, cmd_suspend = 1'b0, cmd_resume = 1'b0, cmd_other = 1'b0;
   logic [IW-1:0] sect_idx = '0;
   logic [NS-1:0] prot_mask = '0;
   logic          us_tick = 1'b0, erase_done = 1'b0;
   logic [IW-1:0] cur_sect, fail_sect;
   logic          win_open, erasing, suspended, all_prot, fail;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   int exp_q[$];

   always #(CLK_P / 2) clk = ~clk;

   sector_erase_sched #(
      .NUM_SECT(NS), .IDX_W(IW), .WIN_TICKS(WIN),
      .NOPROT_TICKS(NPROT), .LIMIT_TICKS(LIMIT), .SCAN_UP(1'b1)
   ) dut_i (
      .clk, .rst_n, .cmd_erase, .cmd_suspend, .cmd_resume, .cmd_other,
      .sect_idx, .prot_mask, .us_tick, .erase_done,
      .cur_sect, .win_open, .erasing, .suspended, .all_prot, .fail, .fail_sect
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // status packed as {win_open, erasing, suspended, all_prot}
   function automatic int status();
      return {28'd0, win_open, erasing, suspended, all_prot};
   endfunction

   task automatic erase_cmd(input int idx);
      @(negedge clk); sect_idx = IW'(idx); cmd_erase = 1'b1;
      @(negedge clk); cmd_erase = 1'b0;
   endtask
   task automatic susp_cmd();
      @(negedge clk); cmd_suspend = 1'b1;
      @(negedge clk); cmd_suspend = 1'b0;
   endtask
   task automatic resume_cmd();
      @(negedge clk); cmd_resume = 1'b1;
      @(negedge clk); cmd_resume = 1'b0;
   endtask
   task automatic other_cmd();
      @(negedge clk); cmd_other = 1'b1;
      @(negedge clk); cmd_other = 1'b0;
   endtask
   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); us_tick = 1'b1;
         @(negedge clk); us_tick = 1'b0;
      end
   endtask
   task automatic done_pulse();
      @(negedge clk); erase_done = 1'b1;
      @(negedge clk); erase_done = 1'b0;
   endtask
   task automatic expect_order(input int s);
      exp_q.push_back(s);
   endtask

   // Monitor: each newly started sector is compared with the scoreboard
   bit tracking = 1'b0;
   int last_sect = -1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!(erasing || suspended)) begin
            tracking = 1'b0;
         end else if (erasing && (!tracking || int'(cur_sect) != last_sect)) begin
            tracking  = 1'b1;
            last_sect = int'(cur_sect);
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R4 actual=%0d expected=none (unexpected sector)", cur_sect);
            end else begin
               chk("R4 erase order", int'(cur_sect), exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      #(CLK_P * 100000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 status", status(), 0);
      chk("R11 fail", int'(fail), 0);

      // R9 idle ignores suspend, resume, other
      susp_cmd(); resume_cmd(); other_cmd(); ticks(WIN + 1);
      chk("R9 idle ignore", status(), 0);

      // R3 out-of-range index
      erase_cmd(7);
      chk("R3 bad index", status(), 0);

      // R1 window restart, R4 ascending order
      expect_order(1); expect_order(5);
      erase_cmd(5);
      chk("R1 window opens", int'(win_open), 1);
      ticks(2);
      erase_cmd(1);
      ticks(WIN - 1);
      chk("R1 restart keeps window", int'(win_open), 1);
      ticks(1);
      chk("R1 erase starts", int'(erasing), 1);
      done_pulse();
      chk("R4 second sector", int'(cur_sect), 5);
      done_pulse();
      chk("R4 batch ends idle", status(), 0);

      // R2 cancel by other command and by resume
      erase_cmd(2);
      other_cmd();
      chk("R2 cancel other", status(), 0);
      ticks(WIN + 1);
      chk("R2 no erase after cancel", status(), 0);
      erase_cmd(2);
      resume_cmd();
      chk("R2 cancel resume", status(), 0);

      // R4 protected sectors skipped (sectors 0 and 2 protected)
      prot_mask = 7'b0000101;
      expect_order(3);
      erase_cmd(0); erase_cmd(2); erase_cmd(3);
      ticks(WIN);
      chk("R4 skip protected", int'(cur_sect), 3);
      done_pulse();
      chk("R4 skip ends idle", status(), 0);

      // R5 all protected
      erase_cmd(0); erase_cmd(2);
      ticks(WIN);
      chk("R5 all_prot set", status(), 1);
      ticks(NPROT - 1);
      chk("R5 all_prot held", int'(all_prot), 1);
      ticks(1);
      chk("R5 all_prot ends", status(), 0);
      prot_mask = '0;

      // R6/R7/R8 suspend during erase
      expect_order(4); expect_order(6);
      erase_cmd(6); erase_cmd(4);
      ticks(WIN);
      chk("R8 erasing first", int'(cur_sect), 4);
      susp_cmd();
      chk("R6 suspended", status(), 2);
      susp_cmd(); erase_cmd(1); other_cmd(); ticks(LIMIT + 2);
      chk("R7 stay suspended", status(), 2);
      resume_cmd();
      chk("R8 resumed", status(), 4);
      chk("R8 same sector", int'(cur_sect), 4);
      resume_cmd();
      chk("R8 resume ignored", status(), 4);
      susp_cmd();
      chk("R8 suspend again", status(), 2);
      resume_cmd();
      done_pulse();
      chk("R8 next sector", int'(cur_sect), 6);
      done_pulse();
      chk("R8 batch done", status(), 0);

      // R6 suspend inside window
      expect_order(3);
      erase_cmd(3);
      susp_cmd();
      chk("R6 window ends on suspend", status(), 2);
      ticks(WIN * 2);
      chk("R7 window stays closed", status(), 2);
      resume_cmd();
      chk("R8 resume after window", int'(cur_sect), 3);
      done_pulse();
      chk("R8 idle", status(), 0);

      // R10 time limit
      expect_order(1);
      erase_cmd(1);
      ticks(WIN);
      ticks(LIMIT - 1);
      chk("R10 not yet failed", int'(fail), 0);
      ticks(1);
      chk("R10 fail set", int'(fail), 1);
      chk("R10 fail sector", int'(fail_sect), 1);
      chk("R10 erase stopped", status(), 0);
      erase_cmd(2);
      chk("R10 fail cleared", int'(fail), 0);
      other_cmd();

      repeat (2) @(negedge clk);
      chk("R4 scoreboard drained", exp_q.size(), 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule